// File: doc/BRIEF.md
# Frequency-Loop Lock Detector with Averaging Correction Filter

This block sits behind the count-error subtractor of a frequency-locked loop. It receives one signed error sample per comparison, together with a valid strobe. It decides whether the loop is locked, and it produces a correction word for the oscillator. Lock is declared only after a run of samples that fall inside a narrow window. Lock is dropped only when a sample leaves a wider window, so small excursions do not cause the flag to chatter.

While the loop is unlocked, each sample passes straight through to the correction word so the loop can pull in quickly. Once the loop is locked, the correction word changes only on every fourth comparison. It then takes the floor-rounded mean of the four newest errors, which trades response speed for lower jitter. Both forms of the correction word are clipped to the signed range of the output.

Top module: `fll_lock_filter`

## Requirements
- R1: While rst_n is low and after its release, locked and filt_upd are 0, filt_val is 0, the sample history is zero and the four-step phase counter is 0.
- R2: A sample qualifies toward lock only when lock_lo < err_in < lock_hi, compared as two's-complement signed values; a sample equal to either bound does not qualify.
- R3: From the unlocked state, locked goes to 1 on the clock edge that captures the need_cnt-th consecutive qualifying valid sample; a need_cnt of 0 acts as 1.
- R4: Before lock is reached, a valid sample that does not qualify restarts the consecutive count from zero; cycles with err_vld low neither advance nor break the run.
- R5: While locked, the block unlocks only on a valid sample with err_in > unlock_hi or err_in < unlock_lo; a sample equal to an unlock bound, or outside the lock window but inside the unlock window, keeps lock.
- R6: A valid sample taken while unlocked (including the sample that completes lock) raises filt_upd for one cycle after its capture edge, with filt_val equal to that sample's error after clipping.
- R7: While locked, every fourth valid sample counted from lock entry raises filt_upd with filt_val = floor((e0+e1+e2+e3)/4) over the four newest samples including the current one; the other locked samples leave filt_upd low and filt_val unchanged.
- R8: The four-step phase counter restarts at lock entry and at unlock, so the first locked average lands on the fourth sample after the one that completed lock.
- R9: filt_val is clipped to the signed range of FILT_W bits (-2048..2047 by default); a value beyond either limit reads as that limit.
- R10: The sample that causes unlock clears locked on its capture edge and updates filt_val with its own clipped error, with filt_upd high.
- R11: In a cycle with err_vld low, filt_upd stays 0 and locked and filt_val keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | ERR_W | Signed count-error sample |
| err_vld | input | 1 | Sample strobe, one cycle per comparison |
| lock_lo | input | ERR_W | Signed lower bound of the lock window (exclusive) |
| lock_hi | input | ERR_W | Signed upper bound of the lock window (exclusive) |
| unlock_lo | input | ERR_W | Signed lower unlock bound |
| unlock_hi | input | ERR_W | Signed upper unlock bound |
| need_cnt | input | CNT_W | Consecutive qualifying samples required for lock |
| locked | output | 1 | Lock flag |
| filt_upd | output | 1 | One-cycle pulse when filt_val is written |
| filt_val | output | FILT_W | Signed, clipped correction word |

## Verification
The bench drives samples that sit exactly on each bound. A design that uses non-strict comparisons would lock too early at the lock bounds, or drop lock at the unlock bounds. It breaks a run of samples with one bound-valued sample and with idle cycles, which shows whether the counter restarts when it should and holds when it should. It places a negative sum of four samples whose division leaves a remainder, so a design that truncates toward zero reads -2 where the correct floor result is -3. It also checks when the first locked average appears, and whether clipping is applied both on the pass-through path and on the averaged path.

// File: rtl/fll_pkg.sv
package fll_pkg;

  // Wide signed working type for all arithmetic; sample widths must stay <= 29 bits.
  typedef logic signed [31:0] wide_t;

  // Open interval test: lo < v < hi.
  function automatic logic in_open(input wide_t v, input wide_t lo, input wide_t hi);
    return (v > lo) && (v < hi);
  endfunction

  // True when v lies beyond either bound of the closed interval [lo, hi].
  function automatic logic beyond(input wide_t v, input wide_t lo, input wide_t hi);
    return (v < lo) || (v > hi);
  endfunction

  // Floor mean of four values: arithmetic shift of the sum.
  function automatic wide_t mean4(input wide_t a, input wide_t b,
                                  input wide_t c, input wide_t d);
    wide_t s;
    s = a + b + c + d;
    return s >>> 2;
  endfunction

  // Clip v to the signed range of w bits.
  function automatic wide_t clip(input wide_t v, input int unsigned w);
    wide_t top, bot;
    top = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
    bot = -top - wide_t'(1);
    if (v > top)      return top;
    else if (v < bot) return bot;
    else              return v;
  endfunction

endpackage

// File: rtl/fll_win_cmp.sv
module fll_win_cmp #(
  parameter int ERR_W = 16
) (
  input  logic signed [ERR_W-1:0] err,
  input  logic signed [ERR_W-1:0] lock_lo,
  input  logic signed [ERR_W-1:0] lock_hi,
  input  logic signed [ERR_W-1:0] unlock_lo,
  input  logic signed [ERR_W-1:0] unlock_hi,
  output logic                    in_lock,
  output logic                    out_unlock
);
  import fll_pkg::*;

  always_comb begin
    in_lock    = in_open(wide_t'(err), wide_t'(lock_lo), wide_t'(lock_hi));
    out_unlock = beyond(wide_t'(err), wide_t'(unlock_lo), wide_t'(unlock_hi));
  end

endmodule

// File: rtl/fll_lock_fsm.sv
module fll_lock_fsm #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld,
  input  logic             in_lock,
  input  logic             out_unlock,
  input  logic [CNT_W-1:0] need,
  output logic             locked,
  output logic             phase_wrap,
  output logic             unlock_ev
);
  localparam int          PH_W    = 2;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(3);
  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_inc;
  logic [CNT_W-1:0] need_eff;
  logic [PH_W-1:0]  phase_q;
  logic             lock_hit;
  logic             lock_ev;

  always_comb begin
    need_eff   = (need == '0) ? CNT_W'(1) : need;
    run_inc    = (run_q == RUN_MAX) ? RUN_MAX : run_q + CNT_W'(1);
    lock_hit   = run_inc >= need_eff;
    lock_ev    = vld && !locked && in_lock && lock_hit;
    unlock_ev  = vld && locked && out_unlock;
    phase_wrap = vld && locked && !out_unlock && (phase_q == PH_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked  <= 1'b0;
      run_q   <= '0;
      phase_q <= '0;
    end else if (vld) begin
      if (!locked) begin
        if (lock_ev) begin
          locked  <= 1'b1;
          run_q   <= '0;
          phase_q <= '0;
        end else if (in_lock) begin
          run_q <= run_inc;
        end else begin
          run_q <= '0;
        end
      end else if (unlock_ev) begin
        locked  <= 1'b0;
        run_q   <= '0;
        phase_q <= '0;
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

  // R3
  lock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(vld && in_lock));

  // R5
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(vld && out_unlock));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |=> $stable(locked));

endmodule

// File: rtl/fll_filter.sv
module fll_filter #(
  parameter int ERR_W  = 16,
  parameter int FILT_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld,
  input  logic signed [ERR_W-1:0]  err,
  input  logic                     locked,
  input  logic                     phase_wrap,
  input  logic                     unlock_ev,
  output logic                     filt_upd,
  output logic signed [FILT_W-1:0] filt_val
);
  import fll_pkg::*;

  localparam int AVG_N  = 4;
  localparam int HIST_N = AVG_N - 1;

  logic signed [ERR_W-1:0] hist_q [HIST_N];
  logic                    upd_now;
  wide_t                   raw_w;
  wide_t                   clip_w;

  always_comb begin
    upd_now = vld && (!locked || unlock_ev || phase_wrap);
    if (phase_wrap)
      raw_w = mean4(wide_t'(err), wide_t'(hist_q[0]), wide_t'(hist_q[1]), wide_t'(hist_q[2]));
    else
      raw_w = wide_t'(err);
    clip_w = clip(raw_w, FILT_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q[0] <= '0;
    else if (vld) hist_q[0] <= err;
  end

  for (genvar i = 1; i < HIST_N; i++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) hist_q[i] <= '0;
      else if (vld) hist_q[i] <= hist_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_upd <= 1'b0;
      filt_val <= '0;
    end else begin
      filt_upd <= upd_now;
      if (upd_now) filt_val <= clip_w[FILT_W-1:0];
    end
  end

  // R6
  unlocked_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !locked |=> filt_upd);

  // R11
  upd_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_upd |-> $past(vld));

  // R7
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_upd && $past(locked) && !$past(unlock_ev) |-> $past(phase_wrap));

endmodule

// File: rtl/fll_lock_filter.sv
module fll_lock_filter #(
  parameter int ERR_W  = 16,
  parameter int FILT_W = 12,
  parameter int CNT_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [ERR_W-1:0]  err_in,
  input  logic                     err_vld,
  input  logic signed [ERR_W-1:0]  lock_lo,
  input  logic signed [ERR_W-1:0]  lock_hi,
  input  logic signed [ERR_W-1:0]  unlock_lo,
  input  logic signed [ERR_W-1:0]  unlock_hi,
  input  logic [CNT_W-1:0]         need_cnt,
  output logic                     locked,
  output logic                     filt_upd,
  output logic signed [FILT_W-1:0] filt_val
);

  logic in_lock_w;
  logic out_unlock_w;
  logic phase_wrap_w;
  logic unlock_ev_w;

  fll_win_cmp #(.ERR_W(ERR_W)) u_cmp (
    .err        (err_in),
    .lock_lo    (lock_lo),
    .lock_hi    (lock_hi),
    .unlock_lo  (unlock_lo),
    .unlock_hi  (unlock_hi),
    .in_lock    (in_lock_w),
    .out_unlock (out_unlock_w)
  );

  fll_lock_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld        (err_vld),
    .in_lock    (in_lock_w),
    .out_unlock (out_unlock_w),
    .need       (need_cnt),
    .locked     (locked),
    .phase_wrap (phase_wrap_w),
    .unlock_ev  (unlock_ev_w)
  );

  fll_filter #(.ERR_W(ERR_W), .FILT_W(FILT_W)) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .vld        (err_vld),
    .err        (err_in),
    .locked     (locked),
    .phase_wrap (phase_wrap_w),
    .unlock_ev  (unlock_ev_w),
    .filt_upd   (filt_upd),
    .filt_val   (filt_val)
  );

  // R10
  unlock_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> filt_upd);

endmodule

// File: tb/tb_fll_lock_filter.sv
`timescale 1ns/1ps
module tb_fll_lock_filter;
  localparam int ERR_W  = 16;
  localparam int FILT_W = 12;
  localparam int CNT_W  = 6;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic signed [ERR_W-1:0]  err_in = '0;
  logic                     err_vld = 1'b0;
  logic signed [ERR_W-1:0]  lock_lo = -16'sd10;
  logic signed [ERR_W-1:0]  lock_hi = 16'sd10;
  logic signed [ERR_W-1:0]  unlock_lo = -16'sd40;
  logic signed [ERR_W-1:0]  unlock_hi = 16'sd40;
  logic [CNT_W-1:0]         need_cnt = 6'd3;
  logic                     locked;
  logic                     filt_upd;
  logic signed [FILT_W-1:0] filt_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  fll_lock_filter #(.ERR_W(ERR_W), .FILT_W(FILT_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .err_vld(err_vld),
    .lock_lo(lock_lo), .lock_hi(lock_hi), .unlock_lo(unlock_lo),
    .unlock_hi(unlock_hi), .need_cnt(need_cnt), .locked(locked),
    .filt_upd(filt_upd), .filt_val(filt_val)
  );

  always #2.5 clk = ~clk;

  function automatic int ref_clip(input int v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  function automatic int ref_floor_mean(input int a, input int b, input int c, input int d);
    int s, q;
    s = a + b + c + d;
    q = s / 4;
    if (s < 0 && (s % 4) != 0) q = q - 1;
    return q;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input int lk, input int upd, input int fv);
    check(req, int'(locked), lk, "locked");
    check(req, int'(filt_upd), upd, "filt_upd");
    check(req, int'(filt_val), fv, "filt_val");
  endtask

  // One valid sample; returns at the negedge after its capture edge.
  task automatic send(input int e);
    @(negedge clk);
    err_in  = ERR_W'(e);
    err_vld = 1'b1;
    @(negedge clk);
    err_vld = 1'b0;
  endtask

  task automatic set_win(input int llo, input int lhi, input int ulo, input int uhi, input int nd);
    lock_lo   = ERR_W'(llo);
    lock_hi   = ERR_W'(lhi);
    unlock_lo = ERR_W'(ulo);
    unlock_hi = ERR_W'(uhi);
    need_cnt  = CNT_W'(nd);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_out("R1", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1", 0, 0, 0);
  endtask

  task automatic t_acquire();
    set_win(-10, 10, -40, 40, 3);
    send(5);   expect_out("R6", 0, 1, 5);
    send(5);   expect_out("R3", 0, 1, 5);
    send(10);  expect_out("R2", 0, 1, 10);   // upper bound does not qualify, run restarts
    send(-10); expect_out("R2", 0, 1, -10);  // lower bound does not qualify
    send(0);   expect_out("R4", 0, 1, 0);
    send(-9);  expect_out("R4", 0, 1, -9);
    repeat (3) begin
      @(negedge clk);
      expect_out("R11", 0, 0, -9);          // idle cycles hold the run
    end
    send(9);   expect_out("R3", 1, 1, 9);   // third consecutive qualifier locks
  endtask

  task automatic t_locked_avg();
    send(20);  expect_out("R5", 1, 0, 9);   // outside lock window, inside unlock window
    send(-40); expect_out("R5", 1, 0, 9);   // equal to unlock bound keeps lock
    send(3);   expect_out("R8", 1, 0, 9);
    send(7);   expect_out("R7", 1, 1, ref_floor_mean(20, -40, 3, 7));
    send(1);   expect_out("R7", 1, 0, -3);
    send(2);   expect_out("R7", 1, 0, -3);
    send(3);   expect_out("R7", 1, 0, -3);
    send(-1);  expect_out("R7", 1, 1, ref_floor_mean(1, 2, 3, -1));
  endtask

  task automatic t_unlock();
    send(41);  expect_out("R10", 0, 1, 41);
    send(30);  expect_out("R6", 0, 1, 30);
    send(-9);  expect_out("R3", 0, 1, -9);
    send(-9);  expect_out("R3", 0, 1, -9);
    send(-9);  expect_out("R3", 1, 1, -9);
    send(-41); expect_out("R5", 0, 1, -41); // below lower unlock bound
  endtask

  task automatic t_need_zero();
    set_win(-10, 10, -40, 40, 0);
    send(0);    expect_out("R3", 1, 1, 0);   // zero acts as one
    send(4);    expect_out("R8", 1, 0, 0);
    send(4);    expect_out("R8", 1, 0, 0);
    send(4);    expect_out("R8", 1, 0, 0);
    send(5);    expect_out("R7", 1, 1, ref_floor_mean(4, 4, 4, 5));
    send(1000); expect_out("R10", 0, 1, 1000);
    send(5000); expect_out("R9", 0, 1, ref_clip(5000));
    send(-3000); expect_out("R9", 0, 1, ref_clip(-3000));
  endtask

  task automatic t_clip_avg();
    set_win(-30000, 30000, -32000, 32000, 1);
    send(8000); expect_out("R9", 1, 1, ref_clip(8000));
    send(8000); expect_out("R8", 1, 0, 2047);
    send(8000); expect_out("R8", 1, 0, 2047);
    send(8000); expect_out("R8", 1, 0, 2047);
    send(-100); expect_out("R9", 1, 1, ref_clip(ref_floor_mean(8000, 8000, 8000, -100)));
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    expect_out("R1", 0, 0, 0);
    rst_n = 1'b1;
    send(12); expect_out("R1", 1, 1, 12);
    send(4);  expect_out("R1", 1, 0, 12);   // phase restarted by reset and lock
    send(4);  expect_out("R1", 1, 0, 12);
    send(4);  expect_out("R1", 1, 0, 12);
    send(-6); expect_out("R7", 1, 1, ref_floor_mean(4, 4, 4, -6));
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_locked_avg();
    t_unlock();
    t_need_zero();
    t_clip_avg();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule